// File: doc/BRIEF.md
# Seeded Rateless Erasure Encoder

The block turns a message held in local storage into an endless stream of coded symbols for a lossy link. The message is K symbols of SYM_WORDS 32-bit words each. For every output symbol, a seed derived from the running symbol number is loaded into a pseudo-random generator. That generator first draws a degree from a programmable cumulative table, then draws that many distinct source symbols. The chosen symbols are combined with bitwise XOR one word at a time. Each word of the result leaves on a valid/ready stream together with the seed. A receiver rebuilds the same neighbour set from the seed alone, so the neighbour list itself is never carried on the link.

Software loads the message through a word write port and sets the message length in bytes. It may also reprogram the degree table. It then pulses `start`. Symbols keep flowing until the consumer raises `ack`. An `ack` only counts once enough symbols have been produced to make decoding likely.

Top module: `lt_fountain_enc`

## Requirements
- R1: After reset, `busy` and `m_valid` are low, and `m_valid` stays low whenever `busy` is low.
- R2: Word address a of the message store holds bytes 4a to 4a+3, with byte 4a in bits 7:0. Source symbol i occupies words i*SYM_WORDS to i*SYM_WORDS+SYM_WORDS-1.
- R3: Every byte whose address is at or above `msg_len` contributes zero to every output word, whatever the store holds there.
- R4: Symbol number n (counted from 0 after `start`) carries on `m_seed` the value v = (n * 0x9E3779B9) XOR 0x5BD1E995, or 1 if v is zero.
- R5: The generator state L is loaded with the seed, and one step maps L to L>>1, XORed with 0xA3000000 when bit 0 of L was 1. The degree is drawn after one step from r = L[15:0]. It equals 1 plus the number of table entries that are at most r, clamped to min(16, K). Every table entry resets to 0xFFFF and is written through `cdf_we`/`cdf_sel`/`cdf_val`.
- R6: After the degree step, each further step yields a candidate index (L[31:16] * K) >> 16. A candidate not yet taken in this symbol is accepted; a repeat is discarded and a new one drawn. This continues until the chosen set has as many members as the degree.
- R7: Output word w of a symbol is the XOR of word w of every chosen source symbol. Each symbol is SYM_WORDS words long, in ascending word order, and `m_last` is high on its final word only.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_last` and `m_seed` hold their values into the next cycle.
- R9: Let N = K + ceil(K/10). An `ack` sampled while fewer than N symbols are complete has no effect. That includes a cycle in which the Nth symbol's final word is accepted. An `ack` sampled once at least N symbols are complete lets the symbol in progress finish, after which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one message word |
| wr_addr | input | ADDR_W | Message word address |
| wr_data | input | 32 | Message word |
| msg_len | input | LEN_W | Message length in bytes, held while busy |
| cdf_we | input | 1 | Write one degree table entry |
| cdf_sel | input | 4 | Degree table entry index |
| cdf_val | input | 16 | Cumulative threshold value |
| start | input | 1 | Begin encoding from symbol 0 |
| ack | input | 1 | Consumer request to stop |
| busy | output | 1 | Encoding in progress |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | 32 | Coded output word |
| m_last | output | 1 | Final word of the symbol |
| m_seed | output | 32 | Seed of the symbol being sent |

## Verification
A stop request and the completion of a symbol can fall in the same clock edge. Whether that `ack` counts then depends on the completed count before the edge. The bench times one `ack` to coincide with the final accepted word of symbol N-1 and another to arrive early in the run, and it expects neither to end the stream. A later `ack`, once N symbols are complete, must end the run after exactly one more symbol. Throughout, every word is compared with a model built from the seed rules, under a throttled `m_ready` as well as a free-running one.

// File: rtl/lt_enc_pkg.sv
package lt_enc_pkg;

  localparam logic [31:0] LFSR_POLY = 32'hA300_0000;
  localparam logic [31:0] SEED_MUL  = 32'h9E37_79B9;
  localparam logic [31:0] SEED_XOR  = 32'h5BD1_E995;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEED, ST_DEG, ST_DSEL, ST_PICK, ST_RD, ST_FIN, ST_OUT
  } enc_state_t;

  // one right-shift Galois step
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_POLY) : (s >> 1);
  endfunction

  // per-symbol seed from the running symbol number, never zero
  function automatic logic [31:0] seed_of(input logic [31:0] n);
    logic [31:0] v;
    v = (n * SEED_MUL) ^ SEED_XOR;
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/lt_msg_store.sv
module lt_msg_store #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lt_prng.sv
module lt_prng (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  output logic [31:0] value
);
  import lt_enc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       value <= 32'd1;
    else if (load) value <= seed;
    else if (step) value <= lfsr_next(value);
  end
endmodule

// File: rtl/lt_degree_table.sv
module lt_degree_table #(
  parameter int ENTRIES = 16,
  parameter int DMAX    = 8,
  parameter int SEL_W   = $clog2(ENTRIES),
  parameter int DEG_W   = $clog2(DMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [15:0]      val,
  input  logic [15:0]      rnd,
  output logic [DEG_W-1:0] deg
);
  logic [15:0] tbl [ENTRIES];
  int unsigned hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 16'hFFFF;
    end else if (we) begin
      tbl[sel] <= val;
    end
  end

  // degree = 1 + thresholds passed, clamped
  always_comb begin
    hits = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rnd >= tbl[i]) hits = hits + 1;
    end
    if (hits + 1 > DMAX) deg = DEG_W'(DMAX);
    else                 deg = DEG_W'(hits + 1);
  end
endmodule

// File: rtl/lt_fountain_enc.sv
module lt_fountain_enc #(
  parameter int K           = 8,
  parameter int SYM_WORDS   = 2,
  parameter int CDF_ENTRIES = 16,
  parameter int ADDR_W      = $clog2(K * SYM_WORDS),
  parameter int LEN_W       = $clog2(K * SYM_WORDS * 4 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              cdf_we,
  input  logic [3:0]        cdf_sel,
  input  logic [15:0]       cdf_val,
  input  logic              start,
  input  logic              ack,
  output logic              busy,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [31:0]       m_data,
  output logic              m_last,
  output logic [31:0]       m_seed
);
  import lt_enc_pkg::*;

  localparam int WORD_B = 4;
  localparam int BSEL_W = $clog2(WORD_B);
  localparam int IDX_W  = (K > 1) ? $clog2(K) : 1;
  localparam int CH_W   = 1 << IDX_W;
  localparam int DMAX   = (K < CDF_ENTRIES) ? K : CDF_ENTRIES;
  localparam int DEG_W  = $clog2(DMAX + 1);
  localparam int PSLOTS = 1 << DEG_W;
  localparam int WSEL_W = (SYM_WORDS > 1) ? $clog2(SYM_WORDS) : 1;
  localparam int N_MIN  = K + (K + 9) / 10;

  enc_state_t        state;
  logic [31:0]       sym_cnt, seed_q, prng_val;
  logic              stop_req, rd_vld_q, cnt_reached, stop_now;
  logic [DEG_W-1:0]  deg_q, deg_drawn, pick_n, rd_j;
  logic [IDX_W-1:0]  picks [PSLOTS];
  logic [CH_W-1:0]   chosen;
  logic [WSEL_W-1:0] word_q;
  logic [ADDR_W-1:0] rd_addr, rd_addr_q;
  logic [31:0]       rdata, masked_q, acc;
  logic [16+IDX_W-1:0] idx_prod;
  logic [IDX_W-1:0]  idx;

  assign busy        = (state != ST_IDLE);
  assign cnt_reached = (sym_cnt >= 32'(N_MIN));
  assign stop_now    = stop_req | (ack & cnt_reached);

  // scale the upper half of the generator onto 0..K-1
  assign idx_prod = {{IDX_W{1'b0}}, prng_val[31:16]} * (16 + IDX_W)'(K);
  assign idx      = idx_prod[16 +: IDX_W];

  assign rd_addr = ADDR_W'(picks[rd_j]) * ADDR_W'(SYM_WORDS) + ADDR_W'(word_q);

  lt_msg_store #(.WORD_W(32), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rdata)
  );

  lt_prng u_prng (
    .clk(clk), .rst(rst),
    .load(state == ST_SEED), .seed(seed_of(sym_cnt)),
    .step(state == ST_DEG || state == ST_DSEL || state == ST_PICK),
    .value(prng_val)
  );

  lt_degree_table #(.ENTRIES(CDF_ENTRIES), .DMAX(DMAX), .SEL_W(4), .DEG_W(DEG_W)) u_deg (
    .clk(clk), .rst(rst), .we(cdf_we), .sel(cdf_sel), .val(cdf_val),
    .rnd(prng_val[15:0]), .deg(deg_drawn)
  );

  // zero padding: bytes at or past msg_len read as zero
  for (genvar b = 0; b < WORD_B; b++) begin : g_pad
    assign masked_q[8*b +: 8] =
      (32'({rd_addr_q, BSEL_W'(b)}) < 32'(msg_len)) ? rdata[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sym_cnt   <= '0;
      seed_q    <= '0;
      stop_req  <= 1'b0;
      deg_q     <= '0;
      pick_n    <= '0;
      rd_j      <= '0;
      chosen    <= '0;
      word_q    <= '0;
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      acc       <= '0;
      m_valid   <= 1'b0;
      m_data    <= '0;
      m_last    <= 1'b0;
      m_seed    <= '0;
      for (int i = 0; i < PSLOTS; i++) picks[i] <= '0;
    end else begin
      rd_vld_q  <= (state == ST_RD);
      rd_addr_q <= rd_addr;
      if (rd_vld_q) acc <= acc ^ masked_q;
      if (state != ST_IDLE && ack && cnt_reached) stop_req <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (start) begin
            sym_cnt  <= '0;
            stop_req <= 1'b0;
            state    <= ST_SEED;
          end
        end
        ST_SEED: begin
          seed_q <= seed_of(sym_cnt);
          chosen <= '0;
          pick_n <= '0;
          word_q <= '0;
          state  <= ST_DEG;
        end
        ST_DEG:  state <= ST_DSEL;
        ST_DSEL: begin
          deg_q <= deg_drawn;
          state <= ST_PICK;
        end
        ST_PICK: begin
          if (!chosen[idx]) begin
            chosen[idx]   <= 1'b1;
            picks[pick_n] <= idx;
            pick_n        <= pick_n + DEG_W'(1);
            if (pick_n + DEG_W'(1) == deg_q) begin
              rd_j  <= '0;
              acc   <= '0;
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          rd_j <= rd_j + DEG_W'(1);
          if (rd_j == deg_q - DEG_W'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          m_data  <= acc ^ masked_q;
          m_valid <= 1'b1;
          m_last  <= (word_q == WSEL_W'(SYM_WORDS - 1));
          m_seed  <= seed_q;
          state   <= ST_OUT;
        end
        ST_OUT: begin
          if (m_ready) begin
            m_valid <= 1'b0;
            if (m_last) begin
              sym_cnt <= sym_cnt + 32'd1;
              state   <= stop_now ? ST_IDLE : ST_SEED;
            end else begin
              word_q <= word_q + WSEL_W'(1);
              rd_j   <= '0;
              acc    <= '0;
              state  <= ST_RD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: stalled output holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_seed) && $stable(m_last)));

  // R6: chosen set size equals the degree once reading starts
  p_distinct_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |-> ($countones(chosen) == int'(deg_q)));

  // R5: degree in range while neighbours are drawn
  p_deg_range_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PICK) |-> (deg_q >= DEG_W'(1) && deg_q <= DEG_W'(DMAX)));

  // R9: a run never ends short of the minimum count
  p_min_count_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sym_cnt >= 32'(N_MIN)));

  // R1: no output while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m_valid);

endmodule

// File: tb/test_lt_fountain_enc.sv
module test_lt_fountain_enc;
  localparam int K   = 8;
  localparam int SW  = 2;
  localparam int TOT = K * SW;
  localparam int N   = K + (K + 9) / 10;
  localparam logic [31:0] POLY = 32'hA300_0000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, cdf_we = 1'b0, start = 1'b0, ack = 1'b0, m_ready = 1'b1;
  logic [3:0]  wr_addr = '0, cdf_sel = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  msg_len = 7'(TOT * 4);
  logic [15:0] cdf_val = '0;
  logic        busy, m_valid, m_last;
  logic [31:0] m_data, m_seed;

  int checks = 0, fails = 0;
  logic [31:0] bmem [TOT];
  logic [15:0] bcdf [16];
  int          blen = TOT * 4;
  int          mp [K];
  int          md;

  always #4 clk = ~clk;

  lt_fountain_enc #(.K(K), .SYM_WORDS(SW)) i_lt_fountain_enc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .msg_len(msg_len), .cdf_we(cdf_we), .cdf_sel(cdf_sel), .cdf_val(cdf_val),
    .start(start), .ack(ack), .busy(busy), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_seed(m_seed)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
  endfunction

  function automatic logic [31:0] seed_n(input int n);
    logic [31:0] v;
    v = (32'(n) * 32'h9E37_79B9) ^ 32'h5BD1_E995;
    return (v == 0) ? 32'd1 : v;
  endfunction

  // R5/R6 model: degree then distinct neighbours from the seed
  task automatic model(input logic [31:0] seed);
    logic [31:0] s;
    int cnt, n, guard, ix;
    bit used [K];
    for (int i = 0; i < K; i++) used[i] = 0;
    s = lstep(seed);
    cnt = 0;
    for (int i = 0; i < 16; i++) if (s[15:0] >= bcdf[i]) cnt++;
    md = (cnt + 1 > K) ? K : cnt + 1;
    s = lstep(s);
    n = 0; guard = 0;
    while (n < md && guard < 10000) begin
      ix = int'((32'(s[31:16]) * 32'(K)) >> 16);
      if (!used[ix]) begin used[ix] = 1; mp[n] = ix; n++; end
      s = lstep(s);
      guard++;
    end
  endtask

  // R2/R3/R7 expected word
  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] e, v;
    int a;
    e = '0;
    for (int j = 0; j < md; j++) begin
      a = mp[j] * SW + w;
      v = bmem[a];
      for (int b = 0; b < 4; b++) if (a * 4 + b >= blen) v[8*b +: 8] = 8'h00;
      e ^= v;
    end
    return e;
  endfunction

  task automatic load_msg(input logic [7:0] salt);
    for (int a = 0; a < TOT; a++) begin
      bmem[a] = {8'(4*a+3) ^ salt, 8'(4*a+2) ^ salt, 8'(4*a+1) ^ salt, 8'(4*a) ^ salt};
      @(negedge clk);
      wr_en = 1; wr_addr = 4'(a); wr_data = bmem[a];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_cdf(input bit graded);
    for (int i = 0; i < 16; i++) begin
      bcdf[i] = (graded && i < 7) ? 16'((i + 1) * 8192) : 16'hFFFF;
      @(negedge clk);
      cdf_we = 1; cdf_sel = 4'(i); cdf_val = bcdf[i];
    end
    @(negedge clk); cdf_we = 0;
  endtask

  task automatic run_enc(input string tag, input int ack_at, input bit stall,
                         input bit early, input int exp_total);
    int cyc, nsym, wi;
    bit ack_done, e1, e2, rdy, hs, a, held;
    logic [31:0] h_data, h_seed;
    logic h_last;
    cyc = 0; nsym = 0; wi = 0; ack_done = 0; e1 = 0; e2 = 0; held = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!busy) break;
      if (held) begin
        chk(m_valid && m_data == h_data && m_seed == h_seed && m_last == h_last,
            "R8 hold under stall", m_data, h_data);
      end
      rdy = !stall || (cyc % 3 == 0);
      hs  = m_valid && rdy;
      a   = 0;
      if (early && !e1 && nsym == 2) begin a = 1; e1 = 1; end
      if (early && !e2 && hs && m_last && nsym == N - 1) begin a = 1; e2 = 1; end
      if (!ack_done && nsym == ack_at) begin a = 1; ack_done = 1; end
      m_ready = rdy; ack = a;
      held = m_valid && !rdy;
      h_data = m_data; h_seed = m_seed; h_last = m_last;
      if (hs) begin
        if (wi == 0) model(seed_n(nsym));
        chk(m_seed == seed_n(nsym), {tag, " R4 seed"}, m_seed, seed_n(nsym));
        chk(m_data == exp_word(wi), {tag, " R7 data"}, m_data, exp_word(wi));
        chk(m_last == (wi == SW - 1), {tag, " R7 last"}, 32'(m_last), 32'(wi == SW - 1));
        wi++;
        if (m_last) begin nsym++; wi = 0; end
      end
    end
    ack = 0; m_ready = 1;
    chk(nsym == exp_total, {tag, " R9 symbol total"}, 32'(nsym), 32'(exp_total));
    chk(!busy && !m_valid, {tag, " R1 idle after stop"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1 reset busy", 32'(busy), 0);
    chk(m_valid == 0, "R1 reset valid", 32'(m_valid), 0);
  endtask

  task automatic t_plain;      // R2 R4 R5 R6 R7 with default table
    blen = TOT * 4; msg_len = 7'(blen);
    run_enc("plain", N, 0, 0, N + 1);
  endtask

  task automatic t_degree;     // R5 R6 with a graded table
    set_cdf(1);
    run_enc("degree", N, 0, 0, N + 1);
  endtask

  task automatic t_padding;    // R3 with a 13 byte message
    load_msg(8'h5C);
    blen = 13; msg_len = 7'(blen);
    run_enc("padding", N + 2, 0, 0, N + 3);
  endtask

  task automatic t_stall;      // R8 throttled consumer
    blen = 29; msg_len = 7'(blen);
    run_enc("stall", N, 1, 0, N + 1);
  endtask

  task automatic t_ack;        // R9 early and coincident ack ignored
    blen = TOT * 4; msg_len = 7'(blen);
    run_enc("ack", N + 1, 1, 1, N + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bcdf[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    load_msg(8'hA0);
    t_plain();
    t_degree();
    t_padding();
    t_stall();
    t_ack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule